// File: doc/BRIEF.md
# Dual-Tap Video Frame Timing Generator

This block produces the outbound video stream of an area-scan camera, one beat per pixel clock. Each beat carries two 8-bit pixels on parallel taps, together with a frame-valid flag and a line-valid flag. A one-cycle start strobe begins a frame. The frame covers a programmable window: its first column, its width in columns, its height in lines, and a horizontal blanking gap between lines. All of these settings, and a 2-bit trim selector, are captured when the frame starts.

Pixels come from an external source. Whenever the fetch enable is high, the block presents a line index and a column address. In that same cycle the source returns two 10-bit samples, one for that column and one for the next. The block cuts each sample to 8 bits and registers both onto the taps, one clock later.

Window settings that break the alignment rules are clamped at frame start. A width that is not a multiple of ten is corrected, and so is a first column that is not ten times an integer plus one. Settings that run past the 1280 × 1024 array are also clamped.

Top module: `vid_tap_framer`

## Requirements
- R1: After reset, and whenever no frame is in progress, frame-valid, line-valid, the fetch enable and both taps are all low.
- R2: Frame-valid rises on the clock edge that samples the start strobe. Line-valid first rises exactly 5 clocks after frame-valid.
- R3: A fetch with column address c and line index r produces the next beat. The sample for (r, c) goes on tap 0 and the sample for (r, c+1) goes on tap 1. Column addresses step by 2 within a line, and lines run from index 0 upward.
- R4: The trim selector picks the 8 bits sent from each 10-bit sample: 0 sends [9:2], 1 sends [8:1], 2 sends [7:0], and 3 behaves as 0.
- R5: The width is rounded down to a multiple of 10. A result of 0 becomes 10, and anything above 1280 becomes 1280. Each line has width/2 beats.
- R6: The first column (1-based) is rounded down to the form 10k+1. A value of 0 becomes 1, and the largest allowed value is 1271. The width is then cut so that the last column is no higher than 1280.
- R7: A height of 0 is sent as 1 line, and a height above 1024 is sent as 1024 lines.
- R8: Between lines, line-valid stays low for exactly the blanking count while frame-valid stays high. A blanking count of 0 acts as 1.
- R9: Frame-valid falls on the same edge as the fall of line-valid after the last beat of the last line. Line-valid is never high while frame-valid is low.
- R10: The start strobe is ignored while frame-valid is high. Changing the settings after the start has no effect on the frame in progress.
- R11: Both taps are zero on every cycle where line-valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle frame start strobe |
| aoi_col_i | input | 11 | First column of the window, 1-based |
| aoi_width_i | input | 11 | Window width in columns |
| aoi_height_i | input | 11 | Window height in lines |
| hblank_i | input | 8 | Blanking clocks between lines |
| shift_i | input | 2 | Trim selector for the 10-to-8-bit cut |
| rd_en_o | output | 1 | Fetch enable to the pixel source |
| rd_col_o | output | 11 | Column address of the tap-0 sample |
| rd_row_o | output | 11 | Line index within the window |
| px0_i | input | 10 | Sample at the fetched column |
| px1_i | input | 10 | Sample at the fetched column plus one |
| fval_o | output | 1 | Frame valid |
| lval_o | output | 1 | Line valid |
| d0_o | output | 8 | Tap 0 pixel |
| d1_o | output | 8 | Tap 1 pixel |

## Verification
The source model returns a value that depends on both line and column, so a swapped tap, a wrong column step or a wrong line index each gives a wrong pixel. Frames are run with aligned settings, with misaligned width and first column, with zero width, height and blanking, and with oversized width and height. These cases separate the rounding, the minimum and the maximum paths of each clamp. A window placed near the right edge checks that the width is cut against the first column. All four trim codes are used, so each bit window, and the fallback of code 3, is observed. One frame receives a second start and new settings while it runs, which shows that the settings were captured at the start.

// File: rtl/vtf_pkg.sv
package vtf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_LINE = 2'd2,
        ST_HBL  = 2'd3
    } vtf_state_e;

    typedef enum logic [1:0] {
        SH_HIGH = 2'd0,
        SH_MID  = 2'd1,
        SH_LOW  = 2'd2,
        SH_RSVD = 2'd3
    } vtf_shift_e;

endpackage

// File: rtl/vtf_aoi_clamp.sv
module vtf_aoi_clamp #(
    parameter int MAX_COLS = 1280,
    parameter int MAX_ROWS = 1024,
    parameter int COL_STEP = 10,
    parameter int COL_W    = 11,
    parameter int ROW_W    = 11,
    parameter int HBL_W    = 8
) (
    input  logic [COL_W-1:0] col_i,
    input  logic [COL_W-1:0] width_i,
    input  logic [ROW_W-1:0] height_i,
    input  logic [HBL_W-1:0] hbl_i,
    output logic [COL_W-1:0] scol_o,
    output logic [COL_W-1:0] pairs_o,
    output logic [ROW_W-1:0] lines_o,
    output logic [HBL_W-1:0] hbl_o
);
    localparam int XW = COL_W + 1;
    localparam logic [XW-1:0]    STEP_X = XW'(COL_STEP);
    localparam logic [XW-1:0]    MAX_X  = XW'(MAX_COLS);
    localparam logic [XW-1:0]    LAST_S = XW'(MAX_COLS - COL_STEP + 1);
    localparam logic [XW-1:0]    ONE_X  = XW'(1);
    localparam logic [ROW_W-1:0] MAX_R  = ROW_W'(MAX_ROWS);

    logic [XW-1:0] s_in, s_al, w_al, room, w_fit;

    always_comb begin
        s_in = (col_i == '0) ? ONE_X : {1'b0, col_i};
        s_al = ((s_in - ONE_X) / STEP_X) * STEP_X + ONE_X;
        if (s_al > LAST_S) s_al = LAST_S;

        w_al = ({1'b0, width_i} / STEP_X) * STEP_X;
        if (w_al == '0)  w_al = STEP_X;
        if (w_al > MAX_X) w_al = MAX_X;

        room  = MAX_X + ONE_X - s_al;
        w_fit = (w_al > room) ? room : w_al;

        scol_o  = s_al[COL_W-1:0];
        pairs_o = w_fit[XW-1:1];

        if (height_i == '0)       lines_o = ROW_W'(1);
        else if (height_i > MAX_R) lines_o = MAX_R;
        else                       lines_o = height_i;

        hbl_o = (hbl_i == '0) ? HBL_W'(1) : hbl_i;
    end

endmodule

// File: rtl/vtf_tap_trim.sv
module vtf_tap_trim
    import vtf_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  sample_i,
    input  logic [1:0]       sel_i,
    output logic [OUT_W-1:0] trim_o
);
    always_comb begin
        case (vtf_shift_e'(sel_i))
            SH_MID:  trim_o = sample_i[IN_W-2 -: OUT_W];
            SH_LOW:  trim_o = sample_i[OUT_W-1:0];
            default: trim_o = sample_i[IN_W-1 -: OUT_W];
        endcase
    end

endmodule

// File: rtl/vid_tap_framer.sv
module vid_tap_framer
    import vtf_pkg::*;
#(
    parameter int MAX_COLS  = 1280,
    parameter int MAX_ROWS  = 1024,
    parameter int COL_STEP  = 10,
    parameter int LEAD_CLKS = 5,
    parameter int IN_W      = 10,
    parameter int OUT_W     = 8,
    parameter int HBL_W     = 8,
    parameter int COL_W     = $clog2(MAX_COLS + 1),
    parameter int ROW_W     = $clog2(MAX_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] aoi_col_i,
    input  logic [COL_W-1:0] aoi_width_i,
    input  logic [ROW_W-1:0] aoi_height_i,
    input  logic [HBL_W-1:0] hblank_i,
    input  logic [1:0]       shift_i,
    output logic             rd_en_o,
    output logic [COL_W-1:0] rd_col_o,
    output logic [ROW_W-1:0] rd_row_o,
    input  logic [IN_W-1:0]  px0_i,
    input  logic [IN_W-1:0]  px1_i,
    output logic             fval_o,
    output logic             lval_o,
    output logic [OUT_W-1:0] d0_o,
    output logic [OUT_W-1:0] d1_o
);
    localparam int TAPS  = 2;
    localparam int CNT_W = HBL_W;
    localparam logic [CNT_W-1:0] LEAD_CNT = CNT_W'(LEAD_CLKS - 2);
    localparam logic [CNT_W-1:0] ONE_N    = CNT_W'(1);
    localparam logic [COL_W-1:0] ONE_C    = COL_W'(1);
    localparam logic [COL_W-1:0] TWO_C    = COL_W'(2);
    localparam logic [ROW_W-1:0] ONE_R    = ROW_W'(1);
    localparam logic [COL_W-1:0] MAX_C    = COL_W'(MAX_COLS);
    localparam logic [ROW_W-1:0] MAX_R    = ROW_W'(MAX_ROWS);

    typedef struct packed {
        vtf_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [COL_W-1:0] scol;
        logic [COL_W-1:0] pairs;
        logic [COL_W-1:0] pc;
        logic [COL_W-1:0] col;
        logic [ROW_W-1:0] lines;
        logic [ROW_W-1:0] row;
        logic [HBL_W-1:0] hbl;
        logic [1:0]       shift;
        logic             fval;
        logic             lval;
        logic [OUT_W-1:0] d0;
        logic [OUT_W-1:0] d1;
    } fr_t;

    fr_t fr_d, fr_q;

    logic [COL_W-1:0] cl_scol, cl_pairs;
    logic [ROW_W-1:0] cl_lines;
    logic [HBL_W-1:0] cl_hbl;

    vtf_aoi_clamp #(
        .MAX_COLS(MAX_COLS), .MAX_ROWS(MAX_ROWS), .COL_STEP(COL_STEP),
        .COL_W(COL_W), .ROW_W(ROW_W), .HBL_W(HBL_W)
    ) u_clamp (
        .col_i   (aoi_col_i),
        .width_i (aoi_width_i),
        .height_i(aoi_height_i),
        .hbl_i   (hblank_i),
        .scol_o  (cl_scol),
        .pairs_o (cl_pairs),
        .lines_o (cl_lines),
        .hbl_o   (cl_hbl)
    );

    logic [IN_W-1:0]  px_a  [TAPS];
    logic [OUT_W-1:0] tap_a [TAPS];

    assign px_a[0] = px0_i;
    assign px_a[1] = px1_i;

    for (genvar t = 0; t < TAPS; t++) begin : g_tap
        vtf_tap_trim #(.IN_W(IN_W), .OUT_W(OUT_W)) u_trim (
            .sample_i(px_a[t]),
            .sel_i   (fr_q.shift),
            .trim_o  (tap_a[t])
        );
    end

    logic go;
    assign go = start_i && !fr_q.fval;

    always_comb begin
        fr_d      = fr_q;
        fr_d.lval = 1'b0;
        fr_d.d0   = '0;
        fr_d.d1   = '0;
        fr_d.fval = (fr_q.st != ST_IDLE) || go;

        case (fr_q.st)
            ST_IDLE: begin
                if (go) begin
                    fr_d.st    = ST_LEAD;
                    fr_d.cnt   = LEAD_CNT;
                    fr_d.scol  = cl_scol;
                    fr_d.col   = cl_scol;
                    fr_d.pairs = cl_pairs;
                    fr_d.lines = cl_lines;
                    fr_d.hbl   = cl_hbl;
                    fr_d.shift = shift_i;
                    fr_d.pc    = '0;
                    fr_d.row   = '0;
                end
            end
            ST_LEAD: begin
                if (fr_q.cnt == '0) fr_d.st  = ST_LINE;
                else                fr_d.cnt = fr_q.cnt - ONE_N;
            end
            ST_LINE: begin
                fr_d.lval = 1'b1;
                fr_d.d0   = tap_a[0];
                fr_d.d1   = tap_a[1];
                if (fr_q.pc == fr_q.pairs - ONE_C) begin
                    fr_d.pc  = '0;
                    fr_d.col = fr_q.scol;
                    if (fr_q.row == fr_q.lines - ONE_R) begin
                        fr_d.st = ST_IDLE;
                    end else begin
                        fr_d.st  = ST_HBL;
                        fr_d.cnt = fr_q.hbl - ONE_N;
                    end
                end else begin
                    fr_d.pc  = fr_q.pc + ONE_C;
                    fr_d.col = fr_q.col + TWO_C;
                end
            end
            ST_HBL: begin
                if (fr_q.cnt == '0) begin
                    fr_d.st  = ST_LINE;
                    fr_d.row = fr_q.row + ONE_R;
                end else begin
                    fr_d.cnt = fr_q.cnt - ONE_N;
                end
            end
            default: fr_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rd_en_o  = (fr_q.st == ST_LINE);
    assign rd_col_o = fr_q.col;
    assign rd_row_o = fr_q.row;
    assign fval_o   = fr_q.fval;
    assign lval_o   = fr_q.lval;
    assign d0_o     = fr_q.d0;
    assign d1_o     = fr_q.d1;

    a_r2_fval_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !fval_o) |=> fval_o);

    a_r3_fetch_to_beat: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> lval_o);

    a_r3_col_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_o && $past(rd_en_o)) |-> (rd_col_o == $past(rd_col_o) + TWO_C));

    a_r6_col_in_array: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_col_o < MAX_C));

    a_r7_row_in_array: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> (rd_row_o < MAX_R));

    a_r9_lval_inside_fval: assert property (@(posedge clk) disable iff (!rst_n)
        lval_o |-> fval_o);

    a_r9_fval_falls_with_lval: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fval_o) |-> $fell(lval_o));

    a_r11_taps_zero_off_line: assert property (@(posedge clk) disable iff (!rst_n)
        !lval_o |-> (d0_o == '0 && d1_o == '0));

endmodule

// File: tb/vid_tap_framer_tb.sv
module vid_tap_framer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [10:0] aoi_col_i = '0;
    logic [10:0] aoi_width_i = '0;
    logic [10:0] aoi_height_i = '0;
    logic [7:0]  hblank_i = '0;
    logic [1:0]  shift_i = '0;
    logic        rd_en_o;
    logic [10:0] rd_col_o;
    logic [10:0] rd_row_o;
    logic [9:0]  px0_i, px1_i;
    logic        fval_o, lval_o;
    logic [7:0]  d0_o, d1_o;

    always #5 clk = ~clk;

    function automatic logic [9:0] pat(input int r, input int c);
        return 10'((r * 7 + c * 3 + 5) % 1024);
    endfunction

    function automatic logic [7:0] trim(input logic [9:0] v, input int sh);
        case (sh)
            1:       return v[8:1];
            2:       return v[7:0];
            default: return v[9:2];
        endcase
    endfunction

    assign px0_i = pat(int'(rd_row_o), int'(rd_col_o));
    assign px1_i = pat(int'(rd_row_o), int'(rd_col_o) + 1);

    vid_tap_framer u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .aoi_col_i(aoi_col_i), .aoi_width_i(aoi_width_i),
        .aoi_height_i(aoi_height_i), .hblank_i(hblank_i), .shift_i(shift_i),
        .rd_en_o(rd_en_o), .rd_col_o(rd_col_o), .rd_row_o(rd_row_o),
        .px0_i(px0_i), .px1_i(px1_i),
        .fval_o(fval_o), .lval_o(lval_o), .d0_o(d0_o), .d1_o(d1_o)
    );

    int nchk = 0;
    int nfail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    typedef struct packed { logic [7:0] d0; logic [7:0] d1; } beat_t;
    beat_t exp_q[$];
    int exp_pairs, exp_lines, exp_hbl;
    int frames_done = 0;

    // scoreboard monitor
    int  cyc = 0;
    bit  prev_f = 0, prev_l = 0, first_line = 0;
    int  f_start = 0, gap = 0, beats = 0, lines_seen = 0;

    always @(negedge clk) begin
        cyc++;
        if (cyc >= 190000) begin
            nfail++; nchk++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
        if (rst_n) begin
            if (lval_o && !fval_o)
                chk(0, "R9", "line valid outside frame", 1, 0);
            if (fval_o && !prev_f) begin
                f_start = cyc; first_line = 1; lines_seen = 0; beats = 0;
            end
            if (fval_o && !lval_o)
                chk(d0_o == 0 && d1_o == 0, "R11", "taps while line low",
                    int'({d0_o, d1_o}), 0);
            if (lval_o && !prev_l) begin
                if (first_line)
                    chk(cyc - f_start == 5, "R2", "fval to first lval", cyc - f_start, 5);
                else
                    chk(gap == exp_hbl, "R8", "blanking gap", gap, exp_hbl);
                first_line = 0; lines_seen++; beats = 0;
            end
            if (lval_o) begin
                beats++;
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "unexpected beat", int'({d0_o, d1_o}), -1);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk({d0_o, d1_o} == e, "R3/R4", "tap pair", int'({d0_o, d1_o}), int'(e));
                end
            end
            if (!lval_o && prev_l)
                chk(beats == exp_pairs, "R5", "beats per line", beats, exp_pairs);
            if (fval_o && !lval_o && !first_line)
                gap = prev_l ? 1 : gap + 1;
            if (!fval_o && prev_f) begin
                chk(prev_l, "R9", "fval falls with lval", int'(prev_l), 1);
                chk(lines_seen == exp_lines, "R7", "lines in frame", lines_seen, exp_lines);
                chk(exp_q.size() == 0, "R3", "beats left over", exp_q.size(), 0);
                frames_done++;
            end
            prev_f = fval_o; prev_l = lval_o;
        end
    end

    // driver: computes expected window and pushes the expected beats
    task automatic run_frame(input int col, input int w, input int h, input int hb,
                             input int sh, input bit poke);
        int s, w2, h2;
        s = (col == 0) ? 1 : col;
        s = ((s - 1) / 10) * 10 + 1;
        if (s > 1271) s = 1271;
        w2 = (w / 10) * 10;
        if (w2 == 0) w2 = 10;
        if (w2 > 1280) w2 = 1280;
        if (w2 > 1281 - s) w2 = 1281 - s;
        h2 = (h == 0) ? 1 : ((h > 1024) ? 1024 : h);
        exp_pairs = w2 / 2;
        exp_lines = h2;
        exp_hbl   = (hb == 0) ? 1 : hb;
        for (int r = 0; r < h2; r++) begin
            for (int k = 0; k < w2 / 2; k++) begin
                beat_t e;
                e.d0 = trim(pat(r, s + 2 * k), sh);
                e.d1 = trim(pat(r, s + 2 * k + 1), sh);
                exp_q.push_back(e);
            end
        end
        @(negedge clk);
        aoi_col_i = 11'(col); aoi_width_i = 11'(w); aoi_height_i = 11'(h);
        hblank_i = 8'(hb); shift_i = 2'(sh); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!fval_o) @(negedge clk);
        if (poke) begin
            repeat (8) @(negedge clk);
            aoi_col_i = 11'd501; aoi_width_i = 11'd60; aoi_height_i = 11'd9;
            hblank_i = 8'd7; shift_i = 2'd2; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (fval_o) @(negedge clk);
        if (poke) begin
            // R10: the extra start must not open a new frame
            for (int i = 0; i < 10; i++) begin
                chk(!fval_o, "R10", "frame after ignored start", int'(fval_o), 0);
                @(negedge clk);
            end
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!fval_o && !lval_o && !rd_en_o && d0_o == 0 && d1_o == 0,
            "R1", "reset state", int'({fval_o, lval_o, rd_en_o}), 0);
        repeat (5) @(negedge clk);
        chk(!fval_o && !lval_o && !rd_en_o, "R1", "idle before start",
            int'({fval_o, lval_o, rd_en_o}), 0);

        run_frame(1, 20, 3, 2, 0, 0);          // R3 basic aligned window
        run_frame(11, 30, 2, 4, 1, 0);         // R4 trim code 1
        run_frame(21, 10, 2, 1, 2, 0);         // R4 trim code 2
        run_frame(31, 20, 2, 3, 3, 0);         // R4 trim code 3 as 0
        run_frame(15, 25, 0, 0, 0, 0);         // R5 R6 R7 R8 rounding / zero
        run_frame(0, 0, 2, 5, 1, 0);           // R5 R6 zero column and width
        run_frame(1, 1280, 2, 3, 0, 0);        // R5 full width
        run_frame(1275, 40, 2, 2, 0, 0);       // R6 right edge cut
        run_frame(101, 2000, 2, 1, 2, 0);      // R5 R6 oversize width
        run_frame(1, 10, 2000, 1, 0, 0);       // R7 oversize height
        run_frame(41, 40, 4, 3, 1, 1);         // R10 start and settings mid-frame

        chk(frames_done == 11, "R2", "frames completed", frames_done, 11);
        chk(!fval_o && !lval_o, "R1", "idle after frames", int'({fval_o, lval_o}), 0);
        summary();
        $finish;
    end

endmodule